// File: doc/BRIEF.md
# Replicated-Bank Multi-Read Register File

This block is a register file with a configurable number of independent read ports. It gets them by placing copies of a two-sided synchronous RAM bank side by side. Every copy sees the same write traffic, so all copies hold the same contents. Each copy then answers reads for its own pair of read ports. Two write ports are provided; a design that needs only one ties the second write enable low.

Each side of a bank has one address input, fed by a 2:1 multiplexer. While that side's write port is active, the multiplexer passes the write address; otherwise it passes the read address of the read port assigned to that side. Writing therefore takes the side away from its read port for that cycle. The read port keeps its last data and raises a per-port flag that marks the result as not refreshed. Read data is registered and appears one clock after the address.

Top module: `rf_multiread`

## Requirements
- R1: A synchronous reset (`rst_n` low at a rising clock edge) clears every `rd_data` lane and every `rd_inval` bit to 0 and sets every stored word to 0.
- R2: A read port with `rd_en` high whose bank side is not writing returns the stored word at its address on `rd_data` after the next rising edge, with `rd_inval` low.
- R3: Write port p (field `wr_addr[p*AW +: AW]`, `wr_data[p*DW +: DW]`) stores its data at its address on a rising edge when `wr_en[p]` is high, and the new word is visible on every read port from the following cycle.
- R4: Read port r is served by bank r/2, on side 0 when r is even and side 1 when r is odd. Write port 0 drives side 0 and write port 1 drives side 1 of every bank. In a cycle where a port's side is writing, that port's `rd_data` keeps its previous value and its `rd_inval` is 1 after the edge.
- R5: A read port with `rd_en` low whose side is not writing keeps its `rd_data` and shows `rd_inval` low.
- R6: A read of an address that the other side writes in the same cycle returns the contents from before that write.
- R7: When both write ports hit the same address in one cycle, the word from write port 1 is kept.
- R8: The number of read ports NUM_RD (2 to 8) sets the bank count to ceil(NUM_RD/2). For an odd count, the spare side of the last bank is unused, and all NUM_RD ports behave as in R2 to R5.
- R9: Read ports are independent: different ports with different addresses in the same cycle each return their own word. Read port r uses field `rd_addr[r*AW +: AW]` and lane `rd_data[r*DW +: DW]`.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge active |
| rst_n | input | 1 | Synchronous reset, active low |
| wr_en | input | 2 | Write enable, bit p for write port p |
| wr_addr | input | 2*AW | Write addresses, port p in bits p*AW +: AW |
| wr_data | input | 2*DW | Write data, port p in bits p*DW +: DW |
| rd_en | input | NUM_RD | Read enable per read port |
| rd_addr | input | NUM_RD*AW | Read addresses, port r in bits r*AW +: AW |
| rd_data | output | NUM_RD*DW | Registered read data, port r in bits r*DW +: DW |
| rd_inval | output | NUM_RD | Set when the port's side was taken for a write |

## Verification
The hardest situations to reach are a read and a write landing on the same bank side, or on the same address from opposite sides, in one cycle. In those cases the hold-and-flag rule or the old-data rule decides the result instead of a plain lookup. Directed tasks set up each case on purpose: one write port alone, the other alone, both together, and a same-address read against a write on the other side. A long random phase on an odd port count then mixes these collisions with ordinary traffic, checked against an array model.

// File: rtl/rf_multiread_pkg.sv
package rf_multiread_pkg;
    localparam int unsigned SIDES = 2;

    function automatic int unsigned bank_count(input int unsigned nports);
        return (nports + SIDES - 1) / SIDES;
    endfunction
endpackage

// File: rtl/rf_port_mux.sv
module rf_port_mux #(
    parameter int AW = 4
) (
    input  logic          use_wr,
    input  logic [AW-1:0] wr_addr,
    input  logic [AW-1:0] rd_addr,
    output logic [AW-1:0] addr
);
    assign addr = use_wr ? wr_addr : rd_addr;
endmodule

// File: rtl/rf_bank.sv
module rf_bank #(
    parameter int AW = 4,
    parameter int DW = 16
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic [1:0]      wr_en,
    input  logic [2*AW-1:0] wr_addr,
    input  logic [2*DW-1:0] wr_data,
    input  logic [1:0]      rd_en,
    input  logic [2*AW-1:0] rd_addr,
    output logic [2*DW-1:0] rd_data,
    output logic [1:0]      rd_inval
);
    localparam int DEPTH = 1 << AW;

    typedef struct packed {
        logic [DEPTH-1:0][DW-1:0] mem;
        logic [1:0][DW-1:0]       rdata;
        logic [1:0]               inval;
    } bank_s;

    bank_s st_d, st_q;
    logic [1:0][AW-1:0] side_addr;

    for (genvar s = 0; s < 2; s++) begin : g_side
        rf_port_mux #(.AW(AW)) u_mux (
            .use_wr  (wr_en[s]),
            .wr_addr (wr_addr[s*AW +: AW]),
            .rd_addr (rd_addr[s*AW +: AW]),
            .addr    (side_addr[s])
        );
    end

    always_comb begin
        st_d = st_q;
        // reads look at the contents before this cycle's writes
        for (int s = 0; s < 2; s++) begin
            if (wr_en[s]) begin
                st_d.inval[s] = 1'b1;
            end else begin
                if (rd_en[s]) begin
                    st_d.rdata[s] = st_q.mem[side_addr[s]];
                end
                st_d.inval[s] = 1'b0;
            end
        end
        // side 1 is applied last, so it wins on a shared address
        for (int s = 0; s < 2; s++) begin
            if (wr_en[s]) begin
                st_d.mem[side_addr[s]] = wr_data[s*DW +: DW];
            end
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign rd_data  = st_q.rdata;
    assign rd_inval = st_q.inval;
endmodule

// File: rtl/rf_multiread.sv
module rf_multiread
    import rf_multiread_pkg::*;
#(
    parameter int NUM_RD = 4,
    parameter int AW     = 4,
    parameter int DW     = 16
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic [1:0]           wr_en,
    input  logic [2*AW-1:0]      wr_addr,
    input  logic [2*DW-1:0]      wr_data,
    input  logic [NUM_RD-1:0]    rd_en,
    input  logic [NUM_RD*AW-1:0] rd_addr,
    output logic [NUM_RD*DW-1:0] rd_data,
    output logic [NUM_RD-1:0]    rd_inval
);
    localparam int NBANK = int'(bank_count(NUM_RD));
    localparam int NSLOT = NBANK * SIDES;

    logic [NSLOT-1:0]    en_pad;
    logic [NSLOT*AW-1:0] addr_pad;
    logic [NSLOT*DW-1:0] data_all;
    logic [NSLOT-1:0]    inval_all;

    assign en_pad   = NSLOT'(rd_en);
    assign addr_pad = (NSLOT*AW)'(rd_addr);

    for (genvar b = 0; b < NBANK; b++) begin : g_bank
        rf_bank #(.AW(AW), .DW(DW)) u_bank (
            .clk      (clk),
            .rst_n    (rst_n),
            .wr_en    (wr_en),
            .wr_addr  (wr_addr),
            .wr_data  (wr_data),
            .rd_en    (en_pad[b*2 +: 2]),
            .rd_addr  (addr_pad[b*2*AW +: 2*AW]),
            .rd_data  (data_all[b*2*DW +: 2*DW]),
            .rd_inval (inval_all[b*2 +: 2])
        );
    end

    if (NSLOT > NUM_RD) begin : g_spare
        logic [DW-1:0] spare_data;
        logic          spare_inval;
        assign spare_data  = data_all[NSLOT*DW-1 -: DW];
        assign spare_inval = inval_all[NSLOT-1];
    end

    assign rd_data  = data_all[NUM_RD*DW-1:0];
    assign rd_inval = inval_all[NUM_RD-1:0];
endmodule

// File: rtl/rf_multiread_chk.sv
module rf_multiread_chk #(
    parameter int NUM_RD = 4,
    parameter int DW     = 16
) (
    input logic                 clk,
    input logic                 rst_n,
    input logic [1:0]           wr_en,
    input logic [NUM_RD-1:0]    rd_en,
    input logic [NUM_RD*DW-1:0] rd_data,
    input logic [NUM_RD-1:0]    rd_inval
);
    logic in_rst_q;

    always_ff @(posedge clk) begin
        in_rst_q <= !rst_n;
    end

    always @(negedge clk) begin
        if (in_rst_q === 1'b1) begin
            a_r1_reset_clear: assert (rd_inval == '0 && rd_data == '0)
                else $error("reset left outputs nonzero");
        end
    end

    for (genvar r = 0; r < NUM_RD; r++) begin : g_port
        localparam int S = r % 2;

        a_r4_steal_flag: assert property (@(posedge clk) disable iff (!rst_n)
            wr_en[S] |=> rd_inval[r]);

        a_r4_steal_hold: assert property (@(posedge clk) disable iff (!rst_n)
            wr_en[S] |=> rd_data[r*DW +: DW] == $past(rd_data[r*DW +: DW]));

        a_r2_read_valid: assert property (@(posedge clk) disable iff (!rst_n)
            (!wr_en[S] && rd_en[r]) |=> !rd_inval[r]);

        a_r5_idle_hold: assert property (@(posedge clk) disable iff (!rst_n)
            (!wr_en[S] && !rd_en[r]) |=> ($stable(rd_data[r*DW +: DW]) && !rd_inval[r]));
    end
endmodule

bind rf_multiread rf_multiread_chk #(.NUM_RD(NUM_RD), .DW(DW)) u_chk (
    .clk      (clk),
    .rst_n    (rst_n),
    .wr_en    (wr_en),
    .rd_en    (rd_en),
    .rd_data  (rd_data),
    .rd_inval (rd_inval)
);

// File: tb/tb_rf_multiread.sv
module tb_rf_multiread;
    localparam int NR    = 5;
    localparam int AW    = 4;
    localparam int DW    = 16;
    localparam int DEPTH = 1 << AW;

    logic                 clk = 1'b0;
    logic                 rst_n = 1'b0;
    logic [1:0]           wr_en = '0;
    logic [2*AW-1:0]      wr_addr = '0;
    logic [2*DW-1:0]      wr_data = '0;
    logic [NR-1:0]        rd_en = '0;
    logic [NR*AW-1:0]     rd_addr = '0;
    logic [NR*DW-1:0]     rd_data;
    logic [NR-1:0]        rd_inval;

    logic [DW-1:0] m_mem [DEPTH];
    logic [DW-1:0] m_q   [NR];
    logic          m_inv [NR];

    int total = 0;
    int bad = 0;
    bit finished = 0;

    always #2.5 clk = ~clk;

    rf_multiread #(.NUM_RD(NR), .AW(AW), .DW(DW)) dut (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr),
        .wr_data(wr_data), .rd_en(rd_en), .rd_addr(rd_addr),
        .rd_data(rd_data), .rd_inval(rd_inval)
    );

    task automatic idle_inputs();
        wr_en = '0; wr_addr = '0; wr_data = '0; rd_en = '0; rd_addr = '0;
    endtask

    task automatic set_wr(input int p, input logic en, input int a, input logic [DW-1:0] d);
        wr_en[p] = en;
        wr_addr[p*AW +: AW] = AW'(a);
        wr_data[p*DW +: DW] = d;
    endtask

    task automatic set_rd(input int r, input logic en, input int a);
        rd_en[r] = en;
        rd_addr[r*AW +: AW] = AW'(a);
    endtask

    task automatic tick(input string tag);
        for (int r = 0; r < NR; r++) begin
            if (wr_en[r % 2]) begin
                m_inv[r] = 1'b1;
            end else begin
                if (rd_en[r]) m_q[r] = m_mem[rd_addr[r*AW +: AW]];
                m_inv[r] = 1'b0;
            end
        end
        for (int p = 0; p < 2; p++) begin
            if (wr_en[p]) m_mem[wr_addr[p*AW +: AW]] = wr_data[p*DW +: DW];
        end
        @(negedge clk);
        for (int r = 0; r < NR; r++) begin
            total++;
            if (rd_data[r*DW +: DW] !== m_q[r] || rd_inval[r] !== m_inv[r]) begin
                bad++;
                $display("FAIL %s port %0d: got data=%h inval=%b, expected data=%h inval=%b",
                         tag, r, rd_data[r*DW +: DW], rd_inval[r], m_q[r], m_inv[r]);
            end
        end
    endtask

    task automatic t_reset();
        idle_inputs();
        rst_n = 1'b0;
        repeat (3) @(negedge clk);
        for (int a = 0; a < DEPTH; a++) m_mem[a] = '0;
        for (int r = 0; r < NR; r++) begin m_q[r] = '0; m_inv[r] = 1'b0; end
        rst_n = 1'b1;
        tick("R1 outputs");
        for (int a = 0; a < DEPTH; a++) begin
            for (int r = 0; r < NR; r++) set_rd(r, 1'b1, a);
            tick("R1 contents");
        end
        idle_inputs();
    endtask

    task automatic t_write_read();
        idle_inputs();
        for (int a = 0; a < DEPTH/2; a++) begin
            set_wr(0, 1'b1, a, DW'(16'hA000 + a));
            set_wr(1, 1'b1, a + DEPTH/2, DW'(16'h5B00 + a));
            tick("R3 write");
        end
        idle_inputs();
        for (int k = 0; k < DEPTH; k++) begin
            for (int r = 0; r < NR; r++) set_rd(r, 1'b1, (k + 3*r) % DEPTH);
            tick("R2 R9 distinct reads");
        end
        idle_inputs();
    endtask

    task automatic t_steal();
        idle_inputs();
        for (int r = 0; r < NR; r++) set_rd(r, 1'b1, r + 1);
        tick("R4 prime");
        for (int r = 0; r < NR; r++) set_rd(r, 1'b1, 12 - r);
        set_wr(0, 1'b1, 14, 16'h1111);
        tick("R4 side0 taken");
        set_wr(0, 1'b0, 0, '0);
        set_wr(1, 1'b1, 15, 16'h2222);
        tick("R4 side1 taken");
        set_wr(0, 1'b1, 2, 16'h3333);
        tick("R4 both taken");
        idle_inputs();
        for (int r = 0; r < NR; r++) set_rd(r, 1'b1, 12 - r);
        tick("R4 recover");
        idle_inputs();
    endtask

    task automatic t_idle();
        idle_inputs();
        for (int r = 0; r < NR; r++) set_rd(r, 1'b0, DEPTH - 1 - r);
        tick("R5 idle");
        for (int r = 0; r < NR; r++) set_rd(r, 1'b0, r);
        tick("R5 idle new addr");
        idle_inputs();
    endtask

    task automatic t_same_cycle();
        idle_inputs();
        for (int r = 0; r < NR; r++) set_rd(r, 1'b1, 5);
        set_wr(0, 1'b1, 5, 16'hBEEF);
        tick("R6 old data");
        set_wr(0, 1'b0, 0, '0);
        tick("R3 new data");
        idle_inputs();
    endtask

    task automatic t_dual_write();
        idle_inputs();
        set_wr(0, 1'b1, 9, 16'h0F0F);
        set_wr(1, 1'b1, 9, 16'hF0F0);
        tick("R7 dual write");
        idle_inputs();
        for (int r = 0; r < NR; r++) set_rd(r, 1'b1, 9);
        tick("R7 port1 wins");
        idle_inputs();
    endtask

    task automatic t_random();
        for (int i = 0; i < 400; i++) begin
            for (int p = 0; p < 2; p++)
                set_wr(p, 1'($urandom_range(0, 3) == 0), int'($urandom_range(0, DEPTH-1)),
                       DW'($urandom));
            for (int r = 0; r < NR; r++)
                set_rd(r, 1'($urandom_range(0, 3) != 0), int'($urandom_range(0, DEPTH-1)));
            tick("R8 random");
        end
        idle_inputs();
    endtask

    task automatic report();
        if (!finished) begin
            finished = 1;
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    endtask

    initial begin
        #(5.0 * 150000);
        bad++;
        total++;
        $display("FAIL watchdog: got timeout, expected completion");
        report();
    end

    initial begin
        t_reset();
        t_write_read();
        t_steal();
        t_idle();
        t_same_cycle();
        t_dual_write();
        t_random();
        report();
    end
endmodule